// File: doc/BRIEF.md
# RF Front-End Control Bus Slave Frame Decoder

This block is the slave side of a two-wire RF front-end control bus. It watches an oversampled copy of the bus clock and the bidirectional data line, recognises the start condition, decodes the command frame and then carries out one of three command sequences: a single register write, an extended (multi-byte) write and a register read. Every frame carries odd parity, and a frame that fails it is dropped. The decoder drives a simple register-file port: a one-cycle write strobe with address and data, and a one-cycle read request whose returned byte is shifted back onto the bus.

The decoder holds its own slave identifier, which matches the low nibble of register 31, defaults to 0111b and is updated whenever an accepted write reaches register 31. Writes addressed to the broadcast identifier 0000b are honoured only for registers 28 to 31, and a read to the broadcast identifier gets no response. All logic runs on one fast system clock. The bus clock and data are sampled as ordinary inputs, and edges are found by comparing successive samples.

Top module: `rffe_slave_decoder`

## Requirements
- R1: A start condition is a data rise and then a data fall, both while the bus clock stays low. It begins a new command frame and abandons any sequence in progress.
- R2: A command frame is 13 bits sampled on bus clock falling edges, MSB first: slave ID (4 bits), code (3 bits), field (5 bits), parity. The block acts only when the ID equals its current slave ID, or the broadcast ID where R8 allows it.
- R3: A frame is valid when its count of ones, including the parity bit, is odd. A bad command frame drops the whole sequence, and a bad data frame of a register write produces no write.
- R4: Code 010 is a register write. The 5-bit field is the address, zero-extended to 8 bits, and one 9-bit data frame follows. An accepted write gives exactly one regWrEn pulse, one clock cycle long.
- R5: Code 000 with field bit 4 clear is an extended write. Field bits 3:0 hold N, an 8-bit start address frame follows, then N+1 data frames, written to consecutive addresses. Code 000 with field bit 4 set is ignored.
- R6: In an extended write, a data frame with bad parity is skipped but the address still advances. A start address frame with bad parity ends the sequence with no writes.
- R7: Code 011 is a read. regRdEn pulses for one cycle with the address, and regRdData must be valid in that cycle. After one idle bus-park cycle, the slave drives D7..D0 and then odd parity on successive bus clock rising edges. On the next rising edge it drives low, and it releases the line at the following falling edge.
- R8: Broadcast ID 0000b: register and extended writes take effect only for addresses 28..31, checked per byte. Reads to the broadcast ID leave the line undriven.
- R9: The slave ID resets to 0111b. An accepted write to address 31 loads data bits 3:0 as the new ID, which governs the next command.
- R10: After reset sdataOe, regWrEn and regRdEn are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Bus clock sample |
| sdataIn | input | 1 | Bus data sample |
| sdataOut | output | 1 | Data driven by the slave during a read |
| sdataOe | output | 1 | Output enable for sdataOut |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrAddr | output | 8 | Write address |
| regWrData | output | 8 | Write data |
| regRdEn | output | 1 | One-cycle register read request |
| regRdAddr | output | 8 | Read address |
| regRdData | input | 8 | Read data, valid while regRdEn is high |

## Verification
A wrong bit counter or frame state shows up quickly at the ports, as a write strobe carrying a shifted address or data byte, or as a missing strobe after the parity bit of the frame concerned. A stale slave ID or broadcast flag surfaces on the next command, which then writes where it should not, or writes nothing where it should. A wrong read phase shows as a read-back word that is off by one bus cycle, or as a line not driven low during the closing park cycle. All of these appear within one sequence of the fault.

// File: rtl/rffe_pkg.sv
package rffe_pkg;
  localparam int SID_W   = 4;
  localparam int CODE_W  = 3;
  localparam int FIELD_W = 5;
  localparam int BYTE_W  = 8;
  localparam int CMD_LEN = SID_W + CODE_W + FIELD_W + 1;
  localparam int DAT_LEN = BYTE_W + 1;
  localparam int CNT_W   = $clog2(CMD_LEN + 1);

  localparam logic [CODE_W-1:0] CODE_WR  = 3'b010;
  localparam logic [CODE_W-1:0] CODE_RD  = 3'b011;
  localparam logic [CODE_W-1:0] CODE_EXT = 3'b000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WDAT, ST_EADR, ST_EDAT, ST_READ
  } stateT;

  // control -> datapath strobes
  typedef struct packed {
    logic clrFrame;
    logic shift;
    logic wr;
    logic loadAddr;
    logic loadAddrWide;
    logic incAddr;
    logic rd;
    logic txShift;
    logic txPark;
    logic txOff;
  } ctlStbT;

  // datapath -> control status
  typedef struct packed {
    logic fall;
    logic rise;
    logic ssc;
    logic parOk;
    logic sidOwn;
    logic sidBc;
    logic fieldInBc;
    logic addrInBc;
    logic [CODE_W-1:0] code;
    logic [FIELD_W-1:0] field;
  } dpStatT;
endpackage

// File: rtl/rffe_dp.sv
module rffe_dp
  import rffe_pkg::*;
#(
  parameter logic [SID_W-1:0]  DEFAULT_SID = 4'b0111,
  parameter logic [SID_W-1:0]  BCAST_SID   = 4'b0000,
  parameter logic [BYTE_W-1:0] BC_LO       = 8'd28,
  parameter logic [BYTE_W-1:0] BC_HI       = 8'd31,
  parameter logic [BYTE_W-1:0] SID_ADDR    = 8'd31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              sdataIn,
  input  ctlStbT            stb,
  output dpStatT            stat,
  output logic              sdataOut,
  output logic              sdataOe,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regRdEn,
  output logic [BYTE_W-1:0] regRdAddr,
  input  logic [BYTE_W-1:0] regRdData
);
  localparam int PAD_W = BYTE_W - FIELD_W;

  logic sclkQ, sclkP, dataQ, dataP, armed;
  logic clkLow, dataRise, sscNow;
  logic [CMD_LEN-1:0] shReg;
  logic [SID_W-1:0]   usid;
  logic [BYTE_W-1:0]  curAddr, byteVal, fieldWide;
  logic [DAT_LEN-1:0] txReg;

  // input sampling and edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0; sclkP <= 1'b0; dataQ <= 1'b0; dataP <= 1'b0; armed <= 1'b0;
    end else begin
      sclkQ <= sclkIn; sclkP <= sclkQ;
      dataQ <= sdataIn; dataP <= dataQ;
      if (!clkLow)       armed <= 1'b0;
      else if (dataRise) armed <= 1'b1;
      else if (sscNow)   armed <= 1'b0;
    end
  end

  assign clkLow   = ~sclkQ & ~sclkP;
  assign dataRise = clkLow & ~dataP & dataQ;
  assign sscNow   = clkLow & armed & dataP & ~dataQ;

  // frame shift register; cleared upper bits keep the parity reduction exact
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shReg <= '0;
    else if (stb.clrFrame) shReg <= '0;
    else if (stb.shift)    shReg <= {shReg[CMD_LEN-2:0], dataQ};
  end

  assign byteVal   = shReg[BYTE_W:1];
  assign fieldWide = {{PAD_W{1'b0}}, stat.field};

  // address pointer, slave ID, register port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0; usid <= DEFAULT_SID;
      regWrEn <= 1'b0; regWrAddr <= '0; regWrData <= '0;
      regRdEn <= 1'b0; regRdAddr <= '0;
    end else begin
      if (stb.loadAddr)          curAddr <= fieldWide;
      else if (stb.loadAddrWide) curAddr <= byteVal;
      else if (stb.incAddr)      curAddr <= curAddr + 1'b1;
      regWrEn <= stb.wr;
      if (stb.wr) begin
        regWrAddr <= curAddr;
        regWrData <= byteVal;
        if (curAddr == SID_ADDR) usid <= byteVal[SID_W-1:0];
      end
      regRdEn <= stb.rd;
      if (stb.rd) regRdAddr <= fieldWide;
    end
  end

  // read return path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0; sdataOut <= 1'b0; sdataOe <= 1'b0;
    end else begin
      if (regRdEn)          txReg <= {regRdData, ~^regRdData};
      else if (stb.txShift) txReg <= {txReg[DAT_LEN-2:0], 1'b0};
      if (stb.txOff) begin
        sdataOe <= 1'b0; sdataOut <= 1'b0;
      end else if (stb.txShift) begin
        sdataOe <= 1'b1; sdataOut <= txReg[DAT_LEN-1];
      end else if (stb.txPark) begin
        sdataOe <= 1'b1; sdataOut <= 1'b0;
      end
    end
  end

  always_comb begin
    stat.fall      = sclkP & ~sclkQ;
    stat.rise      = ~sclkP & sclkQ;
    stat.ssc       = sscNow;
    stat.parOk     = ^shReg;
    stat.sidOwn    = (shReg[CMD_LEN-1 -: SID_W] == usid);
    stat.sidBc     = (shReg[CMD_LEN-1 -: SID_W] == BCAST_SID);
    stat.code      = shReg[FIELD_W+1 +: CODE_W];
    stat.field     = shReg[FIELD_W:1];
    stat.fieldInBc = (fieldWide >= BC_LO) && (fieldWide <= BC_HI);
    stat.addrInBc  = (curAddr >= BC_LO) && (curAddr <= BC_HI);
  end

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  assert_park_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sdataOe) && !$past(sscNow)) |-> ($past(sdataOut) == 1'b0));

  assert_oe_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    sdataOe |-> !regWrEn);

  assert_sid_update_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(usid) |-> (regWrEn && regWrAddr == SID_ADDR));
endmodule

// File: rtl/rffe_ctl.sv
module rffe_ctl
  import rffe_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  dpStatT stat,
  output ctlStbT stb
);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_DAT = CNT_W'(DAT_LEN - 1);
  localparam logic [CNT_W-1:0] RD_FIRST = CNT_W'(1);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(DAT_LEN);
  localparam logic [CNT_W-1:0] RD_PARK  = CNT_W'(DAT_LEN + 1);
  localparam logic [CNT_W-1:0] RD_DONE  = CNT_W'(DAT_LEN + 2);

  stateT state, nxt;
  logic [CNT_W-1:0] bitCnt, rdCnt, lastBit;
  logic evalPend, bcSeq, nxtBc, collecting;
  logic [3:0] byteLeft, nxtLeft;

  assign collecting = (state == ST_CMD) || (state == ST_WDAT) ||
                      (state == ST_EADR) || (state == ST_EDAT);
  assign lastBit = (state == ST_CMD) ? LAST_CMD : LAST_DAT;

  always_comb begin
    stb = '0; nxt = state; nxtLeft = byteLeft; nxtBc = bcSeq;
    if (stat.ssc) begin
      stb.clrFrame = 1'b1; stb.txOff = 1'b1; nxt = ST_CMD;
    end else if (evalPend) begin
      stb.clrFrame = 1'b1; nxt = ST_IDLE;
      case (state)
        ST_CMD: if (stat.parOk) begin
          if (stat.code == CODE_WR && (stat.sidOwn || (stat.sidBc && stat.fieldInBc))) begin
            nxt = ST_WDAT; stb.loadAddr = 1'b1;
          end else if (stat.code == CODE_RD && stat.sidOwn && !stat.sidBc) begin
            nxt = ST_READ; stb.rd = 1'b1;
          end else if (stat.code == CODE_EXT && !stat.field[FIELD_W-1] &&
                       (stat.sidOwn || stat.sidBc)) begin
            nxt = ST_EADR; nxtLeft = stat.field[3:0]; nxtBc = !stat.sidOwn;
          end
        end
        ST_WDAT: stb.wr = stat.parOk;
        ST_EADR: if (stat.parOk) begin
          stb.loadAddrWide = 1'b1; nxt = ST_EDAT;
        end
        ST_EDAT: begin
          stb.incAddr = 1'b1;
          stb.wr = stat.parOk && (!bcSeq || stat.addrInBc);
          if (byteLeft != 4'd0) begin
            nxt = ST_EDAT; nxtLeft = byteLeft - 4'd1;
          end
        end
        default: ;
      endcase
    end else if (collecting && stat.fall) begin
      stb.shift = 1'b1;
    end else if (state == ST_READ) begin
      if (stat.rise) begin
        if (rdCnt >= RD_FIRST && rdCnt <= RD_LAST) stb.txShift = 1'b1;
        else if (rdCnt == RD_PARK) stb.txPark = 1'b1;
      end
      if (stat.fall && rdCnt == RD_DONE) begin
        stb.txOff = 1'b1; nxt = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; bitCnt <= '0; rdCnt <= '0;
      evalPend <= 1'b0; byteLeft <= '0; bcSeq <= 1'b0;
    end else begin
      state <= nxt; byteLeft <= nxtLeft; bcSeq <= nxtBc;
      if (stat.ssc || evalPend) begin
        bitCnt <= '0; rdCnt <= '0; evalPend <= 1'b0;
      end else if (collecting && stat.fall) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == lastBit) evalPend <= 1'b1;
      end else if (state == ST_READ && stat.rise) begin
        rdCnt <= rdCnt + 1'b1;
      end
    end
  end

  assert_bad_cmd_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (evalPend && state == ST_CMD && !stat.parOk && !stat.ssc) |=> (state == ST_IDLE));

  assert_rd_no_wr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ) |-> !stb.wr);

  assert_ssc_restart_R1: assert property (@(posedge clk) disable iff (!rstN)
    stat.ssc |=> (state == ST_CMD && bitCnt == '0));
endmodule

// File: rtl/rffe_slave_decoder.sv
module rffe_slave_decoder
  import rffe_pkg::*;
#(
  parameter logic [3:0] DEFAULT_SID = 4'b0111,
  parameter logic [3:0] BCAST_SID   = 4'b0000,
  parameter logic [7:0] BC_LO       = 8'd28,
  parameter logic [7:0] BC_HI       = 8'd31,
  parameter logic [7:0] SID_ADDR    = 8'd31
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       sdataIn,
  output logic       sdataOut,
  output logic       sdataOe,
  output logic       regWrEn,
  output logic [7:0] regWrAddr,
  output logic [7:0] regWrData,
  output logic       regRdEn,
  output logic [7:0] regRdAddr,
  input  logic [7:0] regRdData
);
  ctlStbT stb;
  dpStatT stat;

  rffe_ctl u_ctl (
    .clk(clk), .rstN(rstN), .stat(stat), .stb(stb)
  );

  rffe_dp #(
    .DEFAULT_SID(DEFAULT_SID), .BCAST_SID(BCAST_SID),
    .BC_LO(BC_LO), .BC_HI(BC_HI), .SID_ADDR(SID_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdataIn(sdataIn),
    .stb(stb), .stat(stat),
    .sdataOut(sdataOut), .sdataOe(sdataOe),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdAddr(regRdAddr), .regRdData(regRdData)
  );
endmodule

// File: tb/sim_rffe_slave_decoder.sv
module sim_rffe_slave_decoder;
  localparam int H = 4;

  logic clk = 1'b0, rstN = 1'b0, sclkIn = 1'b0, sdataIn = 1'b0;
  logic sdataOut, sdataOe, regWrEn, regRdEn;
  logic [7:0] regWrAddr, regWrData, regRdAddr, regRdData;

  logic [7:0] rfMem [0:255];
  logic [7:0] expMem [0:255];
  logic [7:0] logA [0:63], logD [0:63], expA [0:63], expD [0:63];
  logic [7:0] extBuf [0:15];
  int logN = 0, logBase = 0, expN = 0, nChecks = 0, nFails = 0;
  logic [3:0] expSid = 4'b0111;

  always #4 clk = ~clk;

  rffe_slave_decoder u0 (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdataIn(sdataIn),
    .sdataOut(sdataOut), .sdataOe(sdataOe),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  assign regRdData = rfMem[regRdAddr];

  // register file model and write log
  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) rfMem[i] = 8'h00;
    end else if (regWrEn) begin
      if (logN < 64) begin logA[logN] = regWrAddr; logD[logN] = regWrData; end
      logN = logN + 1;
      rfMem[regWrAddr] = regWrData;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit acceptWr(input logic [3:0] sid, input bit own, input logic [7:0] a);
    return own || (sid == 4'd0 && a >= 8'd28 && a <= 8'd31);
  endfunction

  task automatic expPush(input logic [7:0] a, input logic [7:0] d);
    expA[expN] = a; expD[expN] = d; expN++;
    expMem[a] = d;
    if (a == 8'd31) expSid = d[3:0];
  endtask

  task automatic startSeq();
    logBase = logN; expN = 0;
  endtask

  task automatic checkWrites(input string req, input string what);
    bit ok;
    repeat (H) @(negedge clk);
    ok = ((logN - logBase) == expN);
    for (int i = 0; i < expN; i++)
      if (ok && (logA[logBase+i] != expA[i] || logD[logBase+i] != expD[i])) ok = 1'b0;
    check(ok, req, what, logN - logBase, expN);
  endtask

  task automatic sendBit(input logic b);
    sclkIn = 1'b1; sdataIn = b;
    repeat (H) @(negedge clk);
    sclkIn = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic ssc();
    sdataIn = 1'b0; repeat (H) @(negedge clk);
    sdataIn = 1'b1; repeat (H) @(negedge clk);
    sdataIn = 1'b0; repeat (H) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [12:0] v, input int n, input bit bad);
    logic p = 1'b1;
    for (int i = 0; i < n; i++) p = p ^ v[i];
    for (int i = n - 1; i >= 0; i--) sendBit(v[i]);
    sendBit(p ^ bad);
  endtask

  task automatic doWrite(input logic [3:0] sid, input logic [4:0] addr, input logic [7:0] d,
                         input bit badC, input bit badD);
    bit own = (sid == expSid);
    ssc();
    sendFrame({sid, 3'b010, addr}, 12, badC);
    sendFrame({5'b0, d}, 8, badD);
    sendBit(1'b0);
    if (!badC && !badD && acceptWr(sid, own, {3'b0, addr})) expPush({3'b0, addr}, d);
  endtask

  task automatic doExt(input logic [3:0] sid, input bit fMsb, input logic [3:0] cnt,
                       input logic [7:0] start, input bit badC, input bit badA,
                       input logic [15:0] badMask);
    bit own = (sid == expSid);
    bit go = !badC && !fMsb && (own || sid == 4'd0) && !badA;
    ssc();
    sendFrame({sid, 3'b000, fMsb, cnt}, 12, badC);
    sendFrame({5'b0, start}, 8, badA);
    for (int i = 0; i <= int'(cnt); i++) begin
      logic [7:0] a = start + 8'(i);
      sendFrame({5'b0, extBuf[i]}, 8, badMask[i]);
      if (go && !badMask[i] && acceptWr(sid, own, a)) expPush(a, extBuf[i]);
    end
    sendBit(1'b0);
  endtask

  task automatic doRead(input logic [3:0] sid, input logic [4:0] addr, input bit badC,
                        input string req);
    logic [9:0] capOut, capOe, eOut, eOe;
    logic oe0, relOe;
    logic [7:0] d = expMem[{3'b0, addr}];
    bit resp = !badC && sid == expSid && sid != 4'd0;
    ssc();
    sendFrame({sid, 3'b011, addr}, 12, badC);
    sclkIn = 1'b1; sdataIn = 1'b0; repeat (H) @(negedge clk);
    oe0 = sdataOe;
    sclkIn = 1'b0; repeat (H) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      sclkIn = 1'b1; repeat (H) @(negedge clk);
      capOut[9-k] = sdataOut; capOe[9-k] = sdataOe;
      sclkIn = 1'b0; repeat (H) @(negedge clk);
    end
    relOe = sdataOe;
    eOut = resp ? {d, ~^d, 1'b0} : 10'h000;
    eOe  = resp ? 10'h3FF : 10'h000;
    check(capOut == eOut && capOe == eOe, req, "read word/oe", {capOe, capOut}, {eOe, eOut});
    check(!oe0 && !relOe, req, "park cycles undriven", {oe0, relOe}, 0);
  endtask

  task automatic fixSid(inout logic [7:0] d, input logic [7:0] a);
    if (a == 8'd31 && d[3:0] == 4'd0) d[3:0] = 4'd1;
  endtask

  function automatic logic [3:0] otherSid();
    logic [3:0] o;
    do o = 4'($urandom_range(1, 15)); while (o == expSid);
    return o;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    int unsigned seed = $urandom(32'd20240611);
    for (int i = 0; i < 256; i++) expMem[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R10 reset state
    check(!sdataOe && !regWrEn && !regRdEn, "R10", "outputs during reset",
          {sdataOe, regWrEn, regRdEn}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!sdataOe && !regWrEn && !regRdEn, "R10", "outputs after reset",
          {sdataOe, regWrEn, regRdEn}, 0);

    // R2/R4 write to default ID, R7 read back
    startSeq(); doWrite(4'h7, 5'd5, 8'hA5, 0, 0); checkWrites("R4", "write default id");
    doRead(4'h7, 5'd5, 0, "R7");
    // R2 other ID ignored
    startSeq(); doWrite(4'h3, 5'd6, 8'h3C, 0, 0); checkWrites("R2", "foreign id");
    // R3 parity errors
    startSeq(); doWrite(4'h7, 5'd7, 8'h11, 1, 0); checkWrites("R3", "bad cmd parity");
    startSeq(); doWrite(4'h7, 5'd7, 8'h22, 0, 1); checkWrites("R3", "bad data parity");
    doRead(4'h7, 5'd7, 1, "R3");
    // R5 extended write
    for (int i = 0; i < 16; i++) extBuf[i] = 8'(8'h30 + i);
    startSeq(); doExt(4'h7, 0, 4'd3, 8'h40, 0, 0, 16'h0); checkWrites("R5", "ext 4 bytes");
    startSeq(); doExt(4'h7, 1, 4'd1, 8'h50, 0, 0, 16'h0); checkWrites("R5", "ext field msb set");
    startSeq(); doExt(4'h7, 0, 4'd15, 8'h60, 0, 0, 16'h0); checkWrites("R5", "ext 16 bytes");
    // R6 parity inside extended write
    startSeq(); doExt(4'h7, 0, 4'd2, 8'h10, 0, 0, 16'h2); checkWrites("R6", "ext bad middle byte");
    startSeq(); doExt(4'h7, 0, 4'd2, 8'h18, 0, 1, 16'h0); checkWrites("R6", "ext bad address frame");
    // R8 broadcast
    startSeq(); doWrite(4'h0, 5'd28, 8'h5A, 0, 0); checkWrites("R8", "broadcast in range");
    startSeq(); doWrite(4'h0, 5'd9, 8'h5B, 0, 0); checkWrites("R8", "broadcast out of range");
    startSeq(); doExt(4'h0, 0, 4'd2, 8'd26, 0, 0, 16'h0); checkWrites("R8", "broadcast ext straddle");
    doRead(4'h0, 5'd28, 0, "R8");
    // R1 start condition aborts partial frame
    startSeq();
    ssc();
    for (int i = 0; i < 6; i++) sendBit(1'(i & 1));
    doWrite(4'h7, 5'd12, 8'hC3, 0, 0);
    checkWrites("R1", "restart mid frame");
    // R9 slave ID change
    startSeq(); doWrite(4'h7, 5'd31, 8'h2B, 0, 0); checkWrites("R9", "write id reg");
    startSeq(); doWrite(4'h7, 5'd13, 8'h77, 0, 0); checkWrites("R9", "old id ignored");
    startSeq(); doWrite(4'hB, 5'd13, 8'h78, 0, 0); checkWrites("R9", "new id accepted");
    doRead(4'hB, 5'd13, 0, "R9");

    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      int kind = $urandom_range(0, 2);
      int pick = $urandom_range(0, 9);
      logic [3:0] sid = (pick < 6) ? expSid : (pick < 8) ? 4'h0 : otherSid();
      bit bc = ($urandom_range(0, 7) == 0);
      if (kind == 0) begin
        logic [4:0] a = 5'($urandom_range(0, 31));
        logic [7:0] d = 8'($urandom);
        fixSid(d, {3'b0, a});
        startSeq(); doWrite(sid, a, d, bc, ($urandom_range(0, 7) == 0));
        checkWrites("R4", "random write");
      end else if (kind == 1) begin
        logic [3:0] n = 4'($urandom_range(0, 7));
        logic [7:0] st = 8'($urandom_range(0, 40));
        logic [15:0] m = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
        for (int i = 0; i < 16; i++) begin
          logic [7:0] d = 8'($urandom);
          fixSid(d, st + 8'(i));
          extBuf[i] = d;
        end
        startSeq(); doExt(sid, 1'b0, n, st, bc, 1'b0, m);
        checkWrites("R5", "random ext write");
      end else begin
        doRead(sid, 5'($urandom_range(0, 31)), bc, "R7");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule